// File: doc/BRIEF.md
# Round Subkey Generator for a Feistel Block Cipher with a 56-bit Key

This block produces the sixteen 48-bit round subkeys of the classic 64-bit-block, 56-bit-key Feistel cipher one per clock. It does not store them in a table. A 64-bit key is written as two 32-bit words into a key register. A start pulse reduces that key to 56 bits with the standard key selection permutation, which drops the eight parity bits, and splits the result into two 28-bit halves. Each round the halves rotate, and the standard 48-bit compression permutation turns them into that round's subkey.

The same datapath serves both directions. For encryption the halves rotate left and the subkeys appear in order from first to sixteenth. For decryption the first subkey is taken from the unrotated halves, and each later round rotates right by the amount of the matching encryption round counted backwards, so the subkeys appear from sixteenth to first. The round datapath pulls the next subkey with an advance enable. A round index tells it which round is on the output, and a ready flag marks the end of the schedule.

A control state machine paces the sequence. Its states are ST_EMPTY (no key), ST_PART (first key word held), ST_ARMED (full key held), ST_RUN (subkeys on the output) and ST_DONE (schedule finished). Its transitions are: key write from ST_EMPTY to ST_PART; key write from ST_PART to ST_ARMED; start from ST_ARMED, ST_RUN or ST_DONE to ST_RUN; advance on the last round from ST_RUN to ST_DONE; key write from ST_ARMED, ST_RUN or ST_DONE back to ST_PART. A key write takes priority over start, and start takes priority over advance.

Top module: `dsk_subkey_gen`

## Requirements
- R1: A key is two writes on `key_wr`. The first write after reset, or after a full key, fills key bits 1..32, where bit 1 is `key_word[31]` and the most significant key bit. The second write fills bits 33..64. A `start` before both words are held is ignored: `round_idx` stays 0 and `subkey_vld` stays low.
- R2: The first encryption subkey equals the 56-bit key selection of the key, with each 28-bit half rotated left by one, then compressed to 48 bits (subkey bit 1 = `subkey[47]`). For key 0x133457799BBCDFF1 this gives 0x1B02EFFC7072.
- R3: With `decrypt` low at `start`, successive rounds give subkeys 1 to 16. Round n's halves are round n-1's halves rotated left by one in rounds 1, 2, 9 and 16 and by two in all other rounds.
- R4: With `decrypt` high at `start`, round r gives encryption subkey 17-r. Round 1 uses the unrotated halves. For key 0x133457799BBCDFF1, round 1 gives 0xCB3D8B0E17F5.
- R5: While a schedule runs, `subkey_vld` is high and `round_idx` is 1..16. At all other times both are 0.
- R6: Going from one round to the next needs `adv` high on a clock edge. While `adv` is low, the subkey and the round index hold.
- R7: `adv` on round 16 sets `ready`, drops `subkey_vld` and returns `round_idx` to 0. `ready` holds until the next `start` or key write, and a new `start` replays the schedule.
- R8: A key write during a schedule aborts it. On the next cycle `round_idx` is 0, and `subkey_vld` and `ready` are low. That write counts as the first word of a new key.
- R9: A `start` during a schedule restarts it at round 1 in the direction given by `decrypt` at that moment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| key_wr | input | 1 | Key word write strobe |
| key_word | input | 32 | Key word data |
| start | input | 1 | Begin a subkey schedule with the held key |
| decrypt | input | 1 | Direction sampled at start: 1 reverse order, 0 forward |
| adv | input | 1 | Step to the next round |
| subkey | output | 48 | Current round subkey |
| subkey_vld | output | 1 | Subkey output is valid |
| round_idx | output | 5 | Current round 1..16, 0 when not running |
| ready | output | 1 | Schedule finished |

## Verification
Every rotation is cumulative, so a wrong rotation amount or direction in any round corrupts that round's subkey and every subkey after it. The bench compares each of the sixteen subkeys as they appear, and the first wrong round shows up at the port in the cycle it is presented. A control fault shows up in the same cycle as a round index that is off, a valid that stays high, or a ready flag that is missing. A half-register that fails to hold under a stall shows up as a changed subkey on the very next cycle. The bench sweeps several keys in both directions, with and without stalls, and computes every expected subkey by forward-only left rotation, which is a different path from the right rotation used in hardware.

// File: rtl/dsk_pkg.sv
package dsk_pkg;

    localparam int KEY_W  = 64;
    localparam int WORD_W = 32;
    localparam int PERM_W = 56;
    localparam int HALF_W = PERM_W / 2;
    localparam int SUB_W  = 48;
    localparam int ROUNDS = 16;
    localparam int RIDX_W = $clog2(ROUNDS + 1);

    typedef enum logic [2:0] {
        ST_EMPTY,
        ST_PART,
        ST_ARMED,
        ST_RUN,
        ST_DONE
    } ks_state_e;

    // key selection: entry i names the source key bit (1 = MSB) of output bit i+1
    localparam int unsigned SEL_TAB [PERM_W] = '{
        57, 49, 41, 33, 25, 17,  9,  1, 58, 50, 42, 34, 26, 18,
        10,  2, 59, 51, 43, 35, 27, 19, 11,  3, 60, 52, 44, 36,
        63, 55, 47, 39, 31, 23, 15,  7, 62, 54, 46, 38, 30, 22,
        14,  6, 61, 53, 45, 37, 29, 21, 13,  5, 28, 20, 12,  4
    };

    // compression: entry i names the source bit (1 = MSB) of the 56-bit halves
    localparam int unsigned CMP_TAB [SUB_W] = '{
        14, 17, 11, 24,  1,  5,  3, 28, 15,  6, 21, 10,
        23, 19, 12,  4, 26,  8, 16,  7, 27, 20, 13,  2,
        41, 52, 31, 37, 47, 55, 30, 40, 51, 45, 33, 48,
        44, 49, 39, 56, 34, 53, 46, 42, 50, 36, 29, 32
    };

    function automatic logic [PERM_W-1:0] key_select(input logic [KEY_W-1:0] k);
        logic [PERM_W-1:0] r;
        for (int i = 0; i < PERM_W; i++) begin
            r[PERM_W-1-i] = k[KEY_W - int'(SEL_TAB[i])];
        end
        return r;
    endfunction

    function automatic logic [SUB_W-1:0] key_compress(input logic [PERM_W-1:0] cd);
        logic [SUB_W-1:0] r;
        for (int i = 0; i < SUB_W; i++) begin
            r[SUB_W-1-i] = cd[PERM_W - int'(CMP_TAB[i])];
        end
        return r;
    endfunction

    // rounds that rotate by a single position; all others rotate by two
    function automatic logic double_shift(input logic [RIDX_W-1:0] rnd);
        return !(rnd == RIDX_W'(1) || rnd == RIDX_W'(2) ||
                 rnd == RIDX_W'(9) || rnd == RIDX_W'(ROUNDS));
    endfunction

endpackage

// File: rtl/dsk_keyreg.sv
module dsk_keyreg
    import dsk_pkg::*;
#(
    parameter int P_WORD_W = WORD_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr,
    input  logic                  hi_sel,
    input  logic [P_WORD_W-1:0]   word,
    output logic [2*P_WORD_W-1:0] key
);

    localparam int LOCAL_KEY_W = 2 * P_WORD_W;

    logic [LOCAL_KEY_W-1:0] key_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            key_q <= '0;
        end else if (wr) begin
            if (hi_sel) begin
                key_q[LOCAL_KEY_W-1:P_WORD_W] <= word;
            end else begin
                key_q[P_WORD_W-1:0] <= word;
            end
        end
    end

    assign key = key_q;

endmodule

// File: rtl/dsk_halves.sv
module dsk_halves
    import dsk_pkg::*;
#(
    parameter int P_HALF_W = HALF_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  seed_en,
    input  logic                  seed_rotl1,
    input  logic [2*P_HALF_W-1:0] seed_val,
    input  logic                  step_en,
    input  logic                  step_left,
    input  logic                  step_two,
    output logic [2*P_HALF_W-1:0] cd
);

    logic [2*P_HALF_W-1:0] cd_q;

    for (genvar h = 0; h < 2; h++) begin : g_half
        localparam int LO = h * P_HALF_W;
        localparam int HI = LO + P_HALF_W - 1;

        logic [P_HALF_W-1:0] cur;
        logic [P_HALF_W-1:0] seed_h;
        logic [P_HALF_W-1:0] nxt;

        assign cur    = cd_q[HI:LO];
        assign seed_h = seed_val[HI:LO];

        always_comb begin
            nxt = cur;
            if (seed_en) begin
                nxt = seed_rotl1 ? {seed_h[P_HALF_W-2:0], seed_h[P_HALF_W-1]} : seed_h;
            end else if (step_en) begin
                if (step_left) begin
                    nxt = step_two ? {cur[P_HALF_W-3:0], cur[P_HALF_W-1:P_HALF_W-2]}
                                   : {cur[P_HALF_W-2:0], cur[P_HALF_W-1]};
                end else begin
                    nxt = step_two ? {cur[1:0], cur[P_HALF_W-1:2]}
                                   : {cur[0], cur[P_HALF_W-1:1]};
                end
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cd_q[HI:LO] <= '0;
            end else begin
                cd_q[HI:LO] <= nxt;
            end
        end
    end

    assign cd = cd_q;

    // halves change only when seeded or stepped
    assert_halves_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!seed_en && !step_en) |=> $stable(cd_q));

endmodule

// File: rtl/dsk_ctrl.sv
module dsk_ctrl
    import dsk_pkg::*;
#(
    parameter int P_ROUNDS = ROUNDS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_wr,
    input  logic              start,
    input  logic              decrypt,
    input  logic              adv,
    output logic              hi_sel,
    output logic              seed_en,
    output logic              seed_rotl1,
    output logic              step_en,
    output logic              step_left,
    output logic              step_two,
    output logic              running,
    output logic              finished,
    output logic [RIDX_W-1:0] round
);

    localparam logic [RIDX_W-1:0] FIRST = RIDX_W'(1);
    localparam logic [RIDX_W-1:0] LAST  = RIDX_W'(P_ROUNDS);

    ks_state_e         state_q, state_d;
    logic [RIDX_W-1:0] round_q, round_d;
    logic              dec_q, dec_d;
    logic [RIDX_W-1:0] fwd_next;
    logic [RIDX_W-1:0] rev_ref;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
            round_q <= '0;
            dec_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            round_q <= round_d;
            dec_q   <= dec_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        round_d = round_q;
        dec_d   = dec_q;
        seed_en = 1'b0;
        step_en = 1'b0;
        unique case (state_q)
            ST_EMPTY: begin
                if (key_wr) state_d = ST_PART;
            end
            ST_PART: begin
                if (key_wr) state_d = ST_ARMED;
            end
            ST_ARMED, ST_DONE: begin
                if (key_wr) begin
                    state_d = ST_PART;
                end else if (start) begin
                    state_d = ST_RUN;
                    round_d = FIRST;
                    dec_d   = decrypt;
                    seed_en = 1'b1;
                end
            end
            ST_RUN: begin
                if (key_wr) begin
                    state_d = ST_PART;
                    round_d = '0;
                end else if (start) begin
                    round_d = FIRST;
                    dec_d   = decrypt;
                    seed_en = 1'b1;
                end else if (adv) begin
                    if (round_q == LAST) begin
                        state_d = ST_DONE;
                        round_d = '0;
                    end else begin
                        round_d = round_q + FIRST;
                        step_en = 1'b1;
                    end
                end
            end
            default: begin
                state_d = ST_EMPTY;
                round_d = '0;
            end
        endcase
    end

    // outputs
    assign fwd_next = round_q + FIRST;
    assign rev_ref  = RIDX_W'(P_ROUNDS + 1) - round_q;

    always_comb begin
        hi_sel     = (state_q != ST_PART);
        running    = (state_q == ST_RUN);
        finished   = (state_q == ST_DONE);
        round      = round_q;
        seed_rotl1 = !decrypt;
        step_left  = !dec_q;
        step_two   = double_shift(dec_q ? rev_ref : fwd_next);
    end

    assert_idx_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_RUN) |-> (round_q == '0));

    assert_idx_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |-> (round_q >= FIRST && round_q <= LAST));

    assert_stall_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !key_wr && !start && !adv) |=> $stable(round_q));

    assert_step_inc_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !key_wr && !start && adv && round_q != LAST)
            |=> (round_q == $past(round_q) + FIRST));

    assert_finish_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !key_wr && !start && adv && round_q == LAST)
            |=> (state_q == ST_DONE));

    assert_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
        key_wr |=> (round_q == '0 && state_q != ST_RUN && state_q != ST_DONE));

    assert_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !key_wr && start) |=> (round_q == FIRST));

endmodule

// File: rtl/dsk_subkey_gen.sv
module dsk_subkey_gen
    import dsk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_wr,
    input  logic [WORD_W-1:0] key_word,
    input  logic              start,
    input  logic              decrypt,
    input  logic              adv,
    output logic [SUB_W-1:0]  subkey,
    output logic              subkey_vld,
    output logic [RIDX_W-1:0] round_idx,
    output logic              ready
);

    logic              hi_sel;
    logic              seed_en;
    logic              seed_rotl1;
    logic              step_en;
    logic              step_left;
    logic              step_two;
    logic              running;
    logic              finished;
    logic [KEY_W-1:0]  key_q;
    logic [PERM_W-1:0] sel_bits;
    logic [PERM_W-1:0] cd;

    dsk_ctrl #(.P_ROUNDS(ROUNDS)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .key_wr     (key_wr),
        .start      (start),
        .decrypt    (decrypt),
        .adv        (adv),
        .hi_sel     (hi_sel),
        .seed_en    (seed_en),
        .seed_rotl1 (seed_rotl1),
        .step_en    (step_en),
        .step_left  (step_left),
        .step_two   (step_two),
        .running    (running),
        .finished   (finished),
        .round      (round_idx)
    );

    dsk_keyreg #(.P_WORD_W(WORD_W)) u_keyreg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (key_wr),
        .hi_sel (hi_sel),
        .word   (key_word),
        .key    (key_q)
    );

    assign sel_bits = key_select(key_q);

    dsk_halves #(.P_HALF_W(HALF_W)) u_halves (
        .clk        (clk),
        .rst_n      (rst_n),
        .seed_en    (seed_en),
        .seed_rotl1 (seed_rotl1),
        .seed_val   (sel_bits),
        .step_en    (step_en),
        .step_left  (step_left),
        .step_two   (step_two),
        .cd         (cd)
    );

    assign subkey     = key_compress(cd);
    assign subkey_vld = running;
    assign ready      = finished;

    assert_vld_idx_R5: assert property (@(posedge clk) disable iff (!rst_n)
        subkey_vld |-> (round_idx != '0));

    assert_ready_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(ready && subkey_vld));

endmodule

// File: tb/dsk_subkey_gen_tb.sv
`timescale 1ns/1ps
module dsk_subkey_gen_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        key_wr = 1'b0;
    logic [31:0] key_word = '0;
    logic        start = 1'b0;
    logic        decrypt = 1'b0;
    logic        adv = 1'b0;
    logic [47:0] subkey;
    logic        subkey_vld;
    logic [4:0]  round_idx;
    logic        ready;

    int checks = 0;
    int fails  = 0;

    logic [47:0] exp_k [1:16];

    always #2.5 clk = ~clk;

    dsk_subkey_gen dut_i (
        .clk(clk), .rst_n(rst_n), .key_wr(key_wr), .key_word(key_word),
        .start(start), .decrypt(decrypt), .adv(adv), .subkey(subkey),
        .subkey_vld(subkey_vld), .round_idx(round_idx), .ready(ready)
    );

    localparam int unsigned TB_SEL [56] = '{
        57, 49, 41, 33, 25, 17,  9,  1, 58, 50, 42, 34, 26, 18,
        10,  2, 59, 51, 43, 35, 27, 19, 11,  3, 60, 52, 44, 36,
        63, 55, 47, 39, 31, 23, 15,  7, 62, 54, 46, 38, 30, 22,
        14,  6, 61, 53, 45, 37, 29, 21, 13,  5, 28, 20, 12,  4
    };
    localparam int unsigned TB_CMP [48] = '{
        14, 17, 11, 24,  1,  5,  3, 28, 15,  6, 21, 10,
        23, 19, 12,  4, 26,  8, 16,  7, 27, 20, 13,  2,
        41, 52, 31, 37, 47, 55, 30, 40, 51, 45, 33, 48,
        44, 49, 39, 56, 34, 53, 46, 42, 50, 36, 29, 32
    };
    localparam int TB_SHV [16] = '{1, 1, 2, 2, 2, 2, 2, 2, 1, 2, 2, 2, 2, 2, 2, 1};

    // forward-only model: cumulative left rotations from the selected halves
    task automatic build_model(input logic [63:0] k);
        logic [55:0] s;
        logic [27:0] c;
        logic [27:0] d;
        logic [55:0] cd;
        for (int i = 0; i < 56; i++) s[55-i] = k[64 - int'(TB_SEL[i])];
        c = s[55:28];
        d = s[27:0];
        for (int r = 1; r <= 16; r++) begin
            for (int n = 0; n < TB_SHV[r-1]; n++) begin
                c = {c[26:0], c[27]};
                d = {d[26:0], d[27]};
            end
            cd = {c, d};
            for (int i = 0; i < 48; i++) exp_k[r][47-i] = cd[56 - int'(TB_CMP[i])];
        end
    endtask

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic write_key(input logic [63:0] k);
        @(negedge clk); key_wr = 1'b1; key_word = k[63:32];
        @(negedge clk); key_word = k[31:0];
        @(negedge clk); key_wr = 1'b0;
    endtask

    task automatic check_idle(input string tag, input bit exp_ready);
        chk(subkey_vld == 1'b0, tag, 64'(subkey_vld), 64'd0);
        chk(round_idx == 5'd0, tag, 64'(round_idx), 64'd0);
        chk(ready == exp_ready, tag, 64'(ready), 64'(exp_ready));
    endtask

    // full schedule in one direction, optional stalls; ends at negedge after final advance
    task automatic run_schedule(input bit dec, input bit stall);
        @(negedge clk); start = 1'b1; decrypt = dec; adv = 1'b0;
        @(negedge clk); start = 1'b0;
        for (int r = 1; r <= 16; r++) begin
            int e;
            e = dec ? 17 - r : r;
            chk(round_idx == 5'(r), dec ? "R4 index" : "R3 index", 64'(round_idx), 64'(r));
            chk(subkey == exp_k[e], dec ? "R4 subkey" : "R3 subkey", 64'(subkey), 64'(exp_k[e]));
            chk(subkey_vld == 1'b1, "R5 valid", 64'(subkey_vld), 64'd1);
            if (stall && (r % 5 == 2)) begin
                @(negedge clk);
                chk(subkey == exp_k[e], "R6 stall subkey", 64'(subkey), 64'(exp_k[e]));
                chk(round_idx == 5'(r), "R6 stall index", 64'(round_idx), 64'(r));
            end
            adv = 1'b1;
            @(negedge clk); adv = 1'b0;
        end
        check_idle("R7 done", 1'b1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL R7 watchdog expired act=%0d exp=%0d", checks, 0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [63:0] keys [6];
        keys = '{64'h133457799BBCDFF1, 64'h0000000000000000, 64'hFFFFFFFFFFFFFFFF,
                 64'h0123456789ABCDEF, 64'hFEDCBA9876543210, 64'h0E329232EA6D0D73};

        repeat (3) @(negedge clk);
        check_idle("R5 reset", 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R5 after reset", 1'b0);

        // R1: start with no key is ignored
        start = 1'b1;
        @(negedge clk); start = 1'b0;
        @(negedge clk);
        check_idle("R1 start without key", 1'b0);

        // R1: start with only one word is ignored
        @(negedge clk); key_wr = 1'b1; key_word = keys[0][63:32];
        @(negedge clk); key_wr = 1'b0; start = 1'b1;
        @(negedge clk); start = 1'b0;
        check_idle("R1 start half key", 1'b0);
        @(negedge clk); key_wr = 1'b1; key_word = keys[0][31:0];
        @(negedge clk); key_wr = 1'b0;

        // R2 / R4 anchor vectors
        build_model(keys[0]);
        @(negedge clk); start = 1'b1; decrypt = 1'b0;
        @(negedge clk); start = 1'b0;
        chk(subkey == 48'h1B02EFFC7072, "R2 first subkey", 64'(subkey), 64'h1B02EFFC7072);
        chk(round_idx == 5'd1, "R2 index", 64'(round_idx), 64'd1);
        // R9: restart mid-run in reverse direction
        adv = 1'b1;
        repeat (3) @(negedge clk);
        adv = 1'b0;
        chk(round_idx == 5'd4, "R6 advance count", 64'(round_idx), 64'd4);
        start = 1'b1; decrypt = 1'b1;
        @(negedge clk); start = 1'b0;
        chk(subkey == 48'hCB3D8B0E17F5, "R4 anchor", 64'(subkey), 64'hCB3D8B0E17F5);
        chk(round_idx == 5'd1, "R9 restart index", 64'(round_idx), 64'd1);

        // sweep keys in both directions
        for (int k = 0; k < 6; k++) begin
            write_key(keys[k]);
            build_model(keys[k]);
            run_schedule(1'b0, k[0]);
            run_schedule(1'b1, !k[0]);
        end

        // R7: ready holds, restart replays
        repeat (4) @(negedge clk);
        check_idle("R7 ready hold", 1'b1);
        run_schedule(1'b0, 1'b0);

        // R8: abort mid-sequence with a key write
        build_model(keys[3]);
        @(negedge clk); start = 1'b1; decrypt = 1'b0;
        @(negedge clk); start = 1'b0; adv = 1'b1;
        repeat (5) @(negedge clk);
        adv = 1'b0; key_wr = 1'b1; key_word = keys[4][63:32];
        @(negedge clk); key_wr = 1'b0;
        check_idle("R8 abort", 1'b0);
        start = 1'b1;
        @(negedge clk); start = 1'b0;
        check_idle("R8 half key after abort", 1'b0);
        @(negedge clk); key_wr = 1'b1; key_word = keys[4][31:0];
        @(negedge clk); key_wr = 1'b0;
        build_model(keys[4]);
        run_schedule(1'b1, 1'b1);

        // R8: write after done clears ready
        @(negedge clk); key_wr = 1'b1; key_word = keys[5][63:32];
        @(negedge clk); key_wr = 1'b0;
        check_idle("R8 ready cleared", 1'b0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule